// File: doc/BRIEF.md
# Multi-level vectored interrupt controller

This block collects twelve interrupt request sources, groups them into eight priority levels, and presents one winning request to the CPU together with that source's 8-bit vector address. Eight of the sources come from external pins. Each pin is synchronised and edge-detected, and a polarity bit per pin selects the rising or the falling edge. The other four sources are single-cycle pulses from on-chip peripherals. Each source has a pending latch. Software clears that latch. Neither a grant nor an acknowledge touches it.

Arbitration works in two tiers. A software-written rank field orders the eight levels against each other. Inside one level, the source with the lowest vector address always wins. A request can take part only when three things are set: its pending flag, the mask bit of its level, and the global enable. Once a request is granted, the block holds the request strobe and the vector until the CPU pulses acknowledge. That acknowledge also drops the global enable, so nothing else is taken until software sets the enable again.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Source i (0..11) has vector address E0h + 2*i. Its level is: sources 0 and 1 in level 3, sources 2 and 3 in level 4, sources 4 to 7 in level 5, source 8 in level 0, source 9 in level 7, source 10 in level 1, source 11 in level 2. A presented vector is always even and lies between E0h and F6h.
- R2: Sources 0..7 come from `ext_pin[i]` through a two-flop synchroniser. `ext_pol[i]`=1 makes pending set on a rising edge and `ext_pol[i]`=0 on a falling edge. The opposite edge has no effect.
- R3: Sources 8..11 are set pending by any cycle in which `int_req[i-8]` is high.
- R4: A pending flag is cleared only by a high `pend_clr` bit, and a set in the same cycle wins over the clear. Grants and acknowledges leave pending flags unchanged, and no flag sets without a set event.
- R5: A source is eligible only when its pending flag, the `lvl_mask` bit of its level and the global enable are all 1.
- R6: Level L has a 3-bit rank at `lvl_rank[3L+2:3L]`. Among levels with an eligible source, the one with the smallest rank wins, and equal ranks go to the lower-numbered level.
- R7: Inside the winning level, the eligible source with the lowest vector address wins.
- R8: One cycle after a source is chosen, `irq_req` goes to 1 with its vector on `irq_vec`. Both stay unchanged until `irq_ack`, whatever requests arrive in the meantime.
- R9: `irq_ack` clears `irq_req` and `gie` on the next cycle and takes precedence over `gie_set`. No grant is made while `gie` is 0, and a `gie_set` pulse sets it.
- R10: After reset, `irq_req`, `irq_vec` and `gie` are all 0 and every pending flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 8 | External interrupt pins, sources 0..7 |
| ext_pol | input | 8 | Edge select per pin: 1 rising, 0 falling |
| int_req | input | 4 | Peripheral request pulses, sources 8..11 |
| pend_clr | input | 12 | Write-one clear of pending flags, one bit per source |
| lvl_mask | input | 8 | Per-level enable mask, 1 = enabled |
| lvl_rank | input | 24 | Eight 3-bit level ranks, 0 = most urgent |
| gie_set | input | 1 | Pulse that sets the global enable |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the CPU, held until acknowledge |
| irq_vec | output | 8 | Vector address of the granted source |
| gie | output | 1 | Global interrupt enable state |

## Verification
The hardest situation to reach from the ports is a granted request that is held while a more urgent source becomes pending. That case needs correct hold and masking followed by correct re-arbitration. The stimulus reaches it in a fixed order. It first grants a low-priority pin source. It then pulses a level-0 peripheral request while the strobe is held, and checks that the vector stays the same. Next it acknowledges, and checks that the enable drops and that the two pending flags that are still set do not produce a grant. Only after `gie_set` does it expect the level-0 vector. The same-cycle conflicts, set against clear and acknowledge against enable, are driven with both pulses in one cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int N_EXT  = 8;
  localparam int N_INT  = 4;
  localparam int N_SRC  = N_EXT + N_INT;
  localparam int N_LVL  = 8;
  localparam int RANK_W = 3;
  localparam int LVL_W  = $clog2(N_LVL);
  localparam int VEC_W  = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'hE0;

  // level each source belongs to (R1)
  function automatic logic [LVL_W-1:0] src_level(input int idx);
    case (idx)
      0, 1:          return LVL_W'(3);
      2, 3:          return LVL_W'(4);
      4, 5, 6, 7:    return LVL_W'(5);
      8:             return LVL_W'(0);
      9:             return LVL_W'(7);
      10:            return LVL_W'(1);
      default:       return LVL_W'(2);
    endcase
  endfunction

  // vector address: base plus two bytes per source index (R1)
  function automatic logic [VEC_W-1:0] src_vec(input int idx);
    return VEC_BASE + VEC_W'(2 * idx);
  endfunction
endpackage

// File: rtl/irqv_edge_sync.sv
module irqv_edge_sync
  import irqv_pkg::*;
#(
  parameter int NPIN = N_EXT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pol_i,
  output logic [NPIN-1:0] edge_o
);
  logic [NPIN-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic rise_w, fall_w;
    assign rise_w    = sync_q[p] & ~last_q[p];
    assign fall_w    = ~sync_q[p] & last_q[p];
    assign edge_o[p] = pol_i[p] ? rise_w : fall_w;

    // R2: a reported edge matches a real transition of the synchronised pin
    a_r2_edge_real: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o[p] |-> (sync_q[p] != last_q[p]));
  end
endmodule

// File: rtl/irqv_pending.sv
module irqv_pending
  import irqv_pkg::*;
#(
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] pend_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

  // R4: no flag appears without a set event
  a_r4_no_spont_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~$past(pend_o) & ~$past(set_i)) == '0));
  // R4: no flag vanishes without a clear
  a_r4_no_spont_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_o & $past(pend_o) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int NL = N_LVL,
  parameter int RW = RANK_W
) (
  input  logic [NS-1:0]    elig_i,
  input  logic [NL*RW-1:0] rank_i,
  output logic             any_o,
  output logic [NS-1:0]    win_oh_o,
  output logic [VEC_W-1:0] win_vec_o
);
  localparam int LW = $clog2(NL);

  logic [NL-1:0] lvl_hit;
  logic [LW-1:0] best_lvl;
  logic [RW-1:0] best_rk;
  logic          found;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    logic [NS-1:0] members;
    for (genvar s = 0; s < NS; s++) begin : g_mem
      assign members[s] = (src_level(s) == LVL_W'(l));
    end
    assign lvl_hit[l] = |(elig_i & members);
  end

  // tier 1: smallest rank, ties to lower level index (R6)
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_rk  = '1;
    for (int l = 0; l < NL; l++) begin
      if (lvl_hit[l] && (!found || rank_i[l*RW +: RW] < best_rk)) begin
        found    = 1'b1;
        best_lvl = LW'(l);
        best_rk  = rank_i[l*RW +: RW];
      end
    end
  end

  // tier 2: lowest source index inside the level (R7)
  always_comb begin
    win_oh_o  = '0;
    win_vec_o = '0;
    for (int s = NS - 1; s >= 0; s--) begin
      if (elig_i[s] && (src_level(s) == best_lvl)) begin
        win_oh_o  = NS'(1) << s;
        win_vec_o = src_vec(s);
      end
    end
  end

  assign any_o = found;

  always_comb begin
    // R7: at most one winner, and only an eligible one (R5)
    a_r7_one_winner: assert ($onehot0(win_oh_o));
    a_r5_win_eligible: assert ((win_oh_o & ~elig_i) == '0);
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_EXT-1:0]        ext_pin,
  input  logic [N_EXT-1:0]        ext_pol,
  input  logic [N_INT-1:0]        int_req,
  input  logic [N_SRC-1:0]        pend_clr,
  input  logic [N_LVL-1:0]        lvl_mask,
  input  logic [N_LVL*RANK_W-1:0] lvl_rank,
  input  logic                    gie_set,
  input  logic                    irq_ack,
  output logic                    irq_req,
  output logic [VEC_W-1:0]        irq_vec,
  output logic                    gie
);
  logic [N_EXT-1:0] ext_edge;
  logic [N_SRC-1:0] set_w, pend_w, lvl_ok, elig_w, win_oh;
  logic [VEC_W-1:0] win_vec;
  logic             win_any, arb_open;

  irqv_edge_sync #(.NPIN(N_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .pol_i(ext_pol), .edge_o(ext_edge)
  );

  assign set_w = {int_req, ext_edge};

  irqv_pending #(.NS(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(pend_clr), .pend_o(pend_w)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign lvl_ok[s] = lvl_mask[src_level(s)];
  end

  // grants only while enabled, idle and not being acknowledged (R5, R8, R9)
  assign arb_open = gie & ~irq_req & ~irq_ack;
  assign elig_w   = pend_w & lvl_ok & {N_SRC{arb_open}};

  irqv_arbiter #(.NS(N_SRC), .NL(N_LVL), .RW(RANK_W)) u_arb (
    .elig_i(elig_w), .rank_i(lvl_rank), .any_o(win_any),
    .win_oh_o(win_oh), .win_vec_o(win_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      gie     <= 1'b0;
    end else if (irq_ack) begin
      irq_req <= 1'b0;
      gie     <= 1'b0;
    end else begin
      if (gie_set) gie <= 1'b1;
      if (win_any) begin
        irq_req <= 1'b1;
        irq_vec <= win_vec;
      end
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));
  a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_req && !gie));
  a_r9_grant_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(gie));
  a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (!irq_vec[0] && irq_vec >= 8'hE0 && irq_vec <= 8'hF6));
  a_r5_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(pend_w) != '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] RK_ID  = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [23:0] RK_REV = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [23:0] RK_EQ  = 24'd0;
  localparam int NV = 12;
  // {raise[11:0], mask[7:0], rank[23:0], expect_req, expect_vec[7:0]}
  localparam logic [52:0] TBL [NV] = '{
    {12'h001, 8'hFF, RK_ID,  1'b1, 8'hE0},  // R1 single pin source
    {12'h003, 8'hFF, RK_ID,  1'b1, 8'hE0},  // R7 lowest vector in level
    {12'h002, 8'hFF, RK_ID,  1'b1, 8'hE2},  // R1
    {12'hF00, 8'hFF, RK_ID,  1'b1, 8'hF0},  // R3 R6 level 0 wins
    {12'hE00, 8'hFF, RK_ID,  1'b1, 8'hF4},  // R6 level 1 over 2,7
    {12'h0F0, 8'hFF, RK_ID,  1'b1, 8'hE8},  // R7 four in one level
    {12'h0E4, 8'hFF, RK_ID,  1'b1, 8'hE4},  // R6 level 4 over 5
    {12'h300, 8'hFF, RK_REV, 1'b1, 8'hF2},  // R6 reversed ranks
    {12'h0C4, 8'hFF, RK_REV, 1'b1, 8'hEC},  // R6 R7 reversed ranks
    {12'h500, 8'hFE, RK_ID,  1'b1, 8'hF4},  // R5 level 0 masked
    {12'h001, 8'h00, RK_ID,  1'b0, 8'h00},  // R5 all masked
    {12'h801, 8'hFF, RK_EQ,  1'b1, 8'hF6}   // R6 tie to lower level
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ext_pin = '0, ext_pol = 8'hFF, lvl_mask = 8'hFF;
  logic [3:0] int_req = '0;
  logic [11:0] pend_clr = '0;
  logic [23:0] lvl_rank = RK_ID;
  logic gie_set = 1'b0, irq_ack = 1'b0;
  logic irq_req, gie;
  logic [7:0] irq_vec;

  int n_vec = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_pol(ext_pol),
    .int_req(int_req), .pend_clr(pend_clr), .lvl_mask(lvl_mask),
    .lvl_rank(lvl_rank), .gie_set(gie_set), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .gie(gie)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec = n_vec + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic clear_all();
    pend_clr = '1; tick(); pend_clr = '0;
  endtask

  task automatic pulse_gie();
    gie_set = 1'b1; tick(); gie_set = 1'b0;
  endtask

  initial begin
    tick(3);
    // R10 reset state
    chk(irq_req == 1'b0 && gie == 1'b0 && irq_vec == 8'h00, "R10",
        {7'd0, irq_req, irq_vec}, 16'h0000);
    rst_n = 1'b1;
    tick(2);

    for (int v = 0; v < NV; v++) begin
      logic [11:0] raise;
      logic        e_req;
      logic [7:0]  e_vec;
      raise    = TBL[v][52:41];
      lvl_mask = TBL[v][40:33];
      lvl_rank = TBL[v][32:9];
      e_req    = TBL[v][8];
      e_vec    = TBL[v][7:0];
      pulse_ack();
      clear_all();
      ext_pin = raise[7:0];
      int_req = raise[11:8];
      tick();
      int_req = '0;
      tick(4);
      ext_pin = '0;   // falling edge, ignored under rising polarity (R2)
      tick(4);
      pulse_gie();
      tick(3);
      if (e_req)
        chk(irq_req && irq_vec == e_vec, "R6/R7 table", {7'd0, irq_req, irq_vec},
            {8'h01, e_vec});
      else
        chk(!irq_req, "R5 table", {15'd0, irq_req}, 16'd0);
    end

    // R2 falling polarity: rising edge ignored, falling edge sets pending
    lvl_mask = 8'hFF; lvl_rank = RK_ID;
    pulse_ack(); clear_all();
    ext_pol[0] = 1'b0;
    pulse_gie();
    ext_pin[0] = 1'b1; tick(6);
    chk(!irq_req, "R2 wrong edge", {15'd0, irq_req}, 16'd0);
    ext_pin[0] = 1'b0; tick(6);
    chk(irq_req && irq_vec == 8'hE0, "R2 falling edge", {7'd0, irq_req, irq_vec}, 16'h01E0);

    // R8 hold while a more urgent source arrives
    int_req[0] = 1'b1; tick(); int_req[0] = 1'b0; tick(4);
    chk(irq_req && irq_vec == 8'hE0, "R8 held", {7'd0, irq_req, irq_vec}, 16'h01E0);

    // R9 acknowledge drops request and enable
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk(!irq_req && !gie, "R9 ack", {14'd0, irq_req, gie}, 16'd0);
    tick(4);
    chk(!irq_req, "R9 masked after ack", {15'd0, irq_req}, 16'd0);

    // R4 pending survives grant and ack; R6 level 0 now wins
    pulse_gie(); tick(2);
    chk(irq_req && irq_vec == 8'hF0, "R4 pending kept", {7'd0, irq_req, irq_vec}, 16'h01F0);

    // R4 software clear removes pending
    pulse_ack(); clear_all(); pulse_gie(); tick(4);
    chk(!irq_req && gie, "R4 cleared", {14'd0, irq_req, gie}, 16'h0001);

    // R4 set wins over clear in the same cycle (R3 peripheral pulse)
    int_req[0] = 1'b1; pend_clr[8] = 1'b1; tick();
    int_req[0] = 1'b0; pend_clr[8] = 1'b0; tick(3);
    chk(irq_req && irq_vec == 8'hF0, "R4 set over clear", {7'd0, irq_req, irq_vec}, 16'h01F0);

    // R9 acknowledge beats gie_set in the same cycle
    irq_ack = 1'b1; gie_set = 1'b1; tick();
    irq_ack = 1'b0; gie_set = 1'b0;
    chk(!gie && !irq_req, "R9 ack over set", {14'd0, irq_req, gie}, 16'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule